// File: doc/BRIEF.md
# High-Speed Counter Compare Unit

This block keeps a 32-bit up/down pulse count and compares it, on every clock, against a bank of six programmable comparator slots. Each slot is one of three kinds. A set-on-match slot drives a chosen result bit high. A clear-on-match slot drives it low. A range slot drives three adjacent result bits that report whether the count is under, inside or over a signed window. A set-on-match slot can instead be routed to a per-slot interrupt request line.

Equality actions follow the count's movement rather than its value. They fire only when a single up or down step brings the count onto the threshold. A direct load that lands on the same value leaves them silent. Result bits and interrupt requests change on the same clock edge as the count. Software-side logic programs a slot by presenting its kind, limits, destination bit and routing with a write strobe. A separate enable vector turns each slot on or off.

Top module: `hsc_cmp_unit`

## Requirements
- R1: When `cnt_load` is high, `count` takes `load_val` at the next edge. A load has priority over any step in the same cycle.
- R2: Without a load, `cnt_up` alone adds one and `cnt_dn` alone subtracts one, with wrap-around in 32 bits. Both high or both low leaves `count` unchanged.
- R3: An enabled slot of kind 0 (set) drives `flags[dst]` to 1 at the same edge at which a step moves `count` onto its lower threshold. This applies from either direction, for example 199 to 200 and 201 to 200 for a threshold of 200.
- R4: An enabled slot of kind 1 (clear) drives `flags[dst]` to 0 under the same step-onto-threshold condition as R3.
- R5: A load whose value equals a set or clear threshold causes no equality action. A cycle with no step does not cause one either.
- R6: An enabled slot of kind 2 (range) updates `flags[dst]`, `flags[dst+1]` and `flags[dst+2]` at every edge. The indices wrap modulo 16. The three bits mean, in that order, that the new count is below the lower limit, inside the inclusive range, and above the upper limit, all compared as signed values. Exactly one of the three is 1. Kind 3 is idle.
- R7: A configuration write of kind 2 whose lower limit is greater than its upper limit (signed) is rejected. The slot keeps its previous settings, and `cfg_err` is 1 for exactly the cycle after the write.
- R8: A set slot written with `cfg_irq`=1 does not touch `flags`. It pulses `irq_req[slot]` high for one cycle, at the edge where R3 would have set the bit.
- R9: While its `slot_en` bit is 0, a slot changes no result bit. When the slot is enabled again, a range slot refreshes its bits at the next edge, and a set or clear slot stays silent until a step lands on its threshold.
- R10: When several slots write the same result bit in one cycle, the slot with the highest index decides its value.
- R11: After reset `count`, `flags`, `irq_req` and `cfg_err` are 0 and every slot is idle (kind 3).
- R12: A configuration write takes effect from the cycle after the write strobe. A strobe naming a slot number of 6 or above is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_up | input | 1 | Count one step up |
| cnt_dn | input | 1 | Count one step down |
| cnt_load | input | 1 | Load `load_val` into the count |
| load_val | input | 32 | Value for a direct load |
| slot_en | input | 6 | Per-slot enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 3 | Slot number to write |
| cfg_kind | input | 2 | Kind: 0 set, 1 clear, 2 range, 3 idle |
| cfg_lo | input | 32 | Threshold (set/clear) or lower limit (range) |
| cfg_hi | input | 32 | Upper limit (range only) |
| cfg_dst | input | 4 | Destination bit; a range slot uses this bit and the next two |
| cfg_irq | input | 1 | Route a set slot to its interrupt line |
| count | output | 32 | Current count |
| flags | output | 16 | Result register |
| irq_req | output | 6 | Per-slot interrupt request pulses |
| cfg_err | output | 1 | Rejected configuration pulse |

## Verification
The assertions assume that the inputs are steady at each rising edge. They also assume that a range slot only ever holds limits that passed the lower-not-above-upper filter, which the reject path itself guarantees. The random stimulus keeps thresholds, limits and load values inside a narrow signed band around zero, so steps cross thresholds often, and it draws reversed range limits on purpose so that rejects occur. Configuration writes stay on slots 0 to 5. Directed cases add the step-from-both-sides, load-onto-threshold, wrapped range index, interrupt routing and disable/re-enable sequences.

// File: rtl/hsc_cmp_pkg.sv
package hsc_cmp_pkg;

   typedef enum logic [1:0] {
      CK_SET  = 2'd0,
      CK_CLR  = 2'd1,
      CK_ZONE = 2'd2,
      CK_OFF  = 2'd3
   } cmp_kind_e;

   function automatic logic zone_ok(input logic [31:0] lo, input logic [31:0] hi);
      return !($signed(lo) > $signed(hi));
   endfunction

endpackage

// File: rtl/hsc_counter.sv
module hsc_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up,
   input  logic             dn,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] count_nx,
   output logic             stepped
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_comb begin
      stepped  = !load && (up ^ dn);
      count_nx = count_q;
      if (load)
         count_nx = load_val;
      else if (up && !dn)
         count_nx = count_q + ONE;
      else if (dn && !up)
         count_nx = count_q - ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         count_q <= '0;
      else
         count_q <= count_nx;
   end

   p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count_q == $past(load_val));

   p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && up && !dn) |=> count_q == $past(count_q) + ONE);

   p_step_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && dn && !up) |=> count_q == $past(count_q) - ONE);

   p_cancel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && (up == dn)) |=> $stable(count_q));

endmodule

// File: rtl/hsc_cmp_slot.sv
module hsc_cmp_slot
   import hsc_cmp_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int FLAG_W = 16,
   parameter int DST_W  = $clog2(FLAG_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_kind,
   input  logic [CNT_W-1:0]  cfg_lo,
   input  logic [CNT_W-1:0]  cfg_hi,
   input  logic [DST_W-1:0]  cfg_dst,
   input  logic              cfg_irq,
   input  logic              en,
   input  logic              stepped,
   input  logic [CNT_W-1:0]  cnt_nx,
   output logic [FLAG_W-1:0] wr_mask,
   output logic [FLAG_W-1:0] wr_val,
   output logic              irq_hit,
   output logic              cfg_bad
);

   cmp_kind_e          kind_q;
   logic [CNT_W-1:0]   lo_q;
   logic [CNT_W-1:0]   hi_q;
   logic [DST_W-1:0]   dst_q;
   logic               irqm_q;

   logic [DST_W-1:0]   dst_p1;
   logic [DST_W-1:0]   dst_p2;
   logic               eq_hit;
   logic               below;
   logic               above;

   assign cfg_bad = cfg_we && (cmp_kind_e'(cfg_kind) == CK_ZONE) &&
                    ($signed(cfg_lo) > $signed(cfg_hi));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= CK_OFF;
         lo_q   <= '0;
         hi_q   <= '0;
         dst_q  <= '0;
         irqm_q <= 1'b0;
      end else if (cfg_we && !cfg_bad) begin
         kind_q <= cmp_kind_e'(cfg_kind);
         lo_q   <= cfg_lo;
         hi_q   <= cfg_hi;
         dst_q  <= cfg_dst;
         irqm_q <= cfg_irq;
      end
   end

   assign dst_p1 = dst_q + DST_W'(1);
   assign dst_p2 = dst_q + DST_W'(2);
   assign eq_hit = stepped && (cnt_nx == lo_q);
   assign below  = $signed(cnt_nx) < $signed(lo_q);
   assign above  = $signed(cnt_nx) > $signed(hi_q);

   always_comb begin
      wr_mask = '0;
      wr_val  = '0;
      irq_hit = 1'b0;
      if (en) begin
         unique case (kind_q)
            CK_SET: begin
               if (eq_hit) begin
                  if (irqm_q) begin
                     irq_hit = 1'b1;
                  end else begin
                     wr_mask[dst_q] = 1'b1;
                     wr_val[dst_q]  = 1'b1;
                  end
               end
            end
            CK_CLR: begin
               if (eq_hit) begin
                  wr_mask[dst_q] = 1'b1;
                  wr_val[dst_q]  = 1'b0;
               end
            end
            CK_ZONE: begin
               wr_mask[dst_q]  = 1'b1;
               wr_mask[dst_p1] = 1'b1;
               wr_mask[dst_p2] = 1'b1;
               wr_val[dst_q]   = below;
               wr_val[dst_p1]  = !below && !above;
               wr_val[dst_p2]  = above;
            end
            default: begin
               wr_mask = '0;
            end
         endcase
      end
   end

   p_reject_keeps_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_bad |=> ($stable(lo_q) && $stable(hi_q) && $stable(kind_q) && $stable(dst_q)));

   p_zone_limits_ordered_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == CK_ZONE) |-> zone_ok(32'(lo_q), 32'(hi_q)));

   p_zone_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && kind_q == CK_ZONE) |-> ($countones(wr_val) == 1 && $countones(wr_mask) == 3));

   p_no_match_without_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!stepped && kind_q != CK_ZONE) |-> (wr_mask == '0 && !irq_hit));

endmodule

// File: rtl/hsc_flag_merge.sv
module hsc_flag_merge #(
   parameter int N_SLOTS = 6,
   parameter int FLAG_W  = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [N_SLOTS-1:0][FLAG_W-1:0] wr_mask,
   input  logic [N_SLOTS-1:0][FLAG_W-1:0] wr_val,
   input  logic [N_SLOTS-1:0]             irq_hit,
   output logic [FLAG_W-1:0]              flags_q,
   output logic [N_SLOTS-1:0]             irq_q
);

   logic [FLAG_W-1:0] stage [N_SLOTS+1];

   assign stage[0] = flags_q;

   // Later slots overwrite earlier ones, giving the highest index the last word.
   for (genvar g = 0; g < N_SLOTS; g++) begin : g_chain
      assign stage[g+1] = (stage[g] & ~wr_mask[g]) | (wr_val[g] & wr_mask[g]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         irq_q   <= '0;
      end else begin
         flags_q <= stage[N_SLOTS];
         irq_q   <= irq_hit;
      end
   end

   p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(|wr_mask) |=> flags_q == $past(flags_q));

   p_top_slot_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mask[N_SLOTS-1] != '0) |=>
         ((flags_q & $past(wr_mask[N_SLOTS-1])) == ($past(wr_val[N_SLOTS-1]) & $past(wr_mask[N_SLOTS-1]))));

endmodule

// File: rtl/hsc_cmp_unit.sv
module hsc_cmp_unit #(
   parameter int CNT_W   = 32,
   parameter int N_SLOTS = 6,
   parameter int FLAG_W  = 16,
   parameter int SLOT_W  = $clog2(N_SLOTS),
   parameter int DST_W   = $clog2(FLAG_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cnt_up,
   input  logic               cnt_dn,
   input  logic               cnt_load,
   input  logic [CNT_W-1:0]   load_val,
   input  logic [N_SLOTS-1:0] slot_en,
   input  logic               cfg_we,
   input  logic [SLOT_W-1:0]  cfg_slot,
   input  logic [1:0]         cfg_kind,
   input  logic [CNT_W-1:0]   cfg_lo,
   input  logic [CNT_W-1:0]   cfg_hi,
   input  logic [DST_W-1:0]   cfg_dst,
   input  logic               cfg_irq,
   output logic [CNT_W-1:0]   count,
   output logic [FLAG_W-1:0]  flags,
   output logic [N_SLOTS-1:0] irq_req,
   output logic               cfg_err
);

   if (CNT_W < 8) begin : g_chk_cnt
      $error("hsc_cmp_unit: CNT_W must be at least 8");
   end
   if (N_SLOTS < 2 || N_SLOTS > (1 << SLOT_W)) begin : g_chk_slots
      $error("hsc_cmp_unit: N_SLOTS out of range for SLOT_W");
   end
   if (FLAG_W < 4 || (FLAG_W & (FLAG_W - 1)) != 0) begin : g_chk_flags
      $error("hsc_cmp_unit: FLAG_W must be a power of two, at least 4");
   end

   logic [CNT_W-1:0]               cnt_nx;
   logic                           stepped;
   logic [N_SLOTS-1:0][FLAG_W-1:0] wr_mask;
   logic [N_SLOTS-1:0][FLAG_W-1:0] wr_val;
   logic [N_SLOTS-1:0]             irq_hit;
   logic [N_SLOTS-1:0]             bad;
   logic                           err_q;

   hsc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .up       (cnt_up),
      .dn       (cnt_dn),
      .load     (cnt_load),
      .load_val (load_val),
      .count_q  (count),
      .count_nx (cnt_nx),
      .stepped  (stepped)
   );

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      logic we_g;
      assign we_g = cfg_we && (cfg_slot == SLOT_W'(g));

      hsc_cmp_slot #(
         .CNT_W  (CNT_W),
         .FLAG_W (FLAG_W),
         .DST_W  (DST_W)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (we_g),
         .cfg_kind (cfg_kind),
         .cfg_lo   (cfg_lo),
         .cfg_hi   (cfg_hi),
         .cfg_dst  (cfg_dst),
         .cfg_irq  (cfg_irq),
         .en       (slot_en[g]),
         .stepped  (stepped),
         .cnt_nx   (cnt_nx),
         .wr_mask  (wr_mask[g]),
         .wr_val   (wr_val[g]),
         .irq_hit  (irq_hit[g]),
         .cfg_bad  (bad[g])
      );
   end

   hsc_flag_merge #(
      .N_SLOTS (N_SLOTS),
      .FLAG_W  (FLAG_W)
   ) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_mask (wr_mask),
      .wr_val  (wr_val),
      .irq_hit (irq_hit),
      .flags_q (flags),
      .irq_q   (irq_req)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         err_q <= 1'b0;
      else
         err_q <= |bad;
   end

   assign cfg_err = err_q;

   p_irq_after_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_req) |-> $past(stepped));

   p_err_from_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $past(cfg_we));

   p_load_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load |=> (irq_req == '0));

endmodule

// File: tb/hsc_cmp_unit_tb.sv
module hsc_cmp_unit_tb;

   localparam int NS = 6;
   localparam int FW = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cnt_up, cnt_dn, cnt_load;
   logic [31:0] load_val;
   logic [NS-1:0] slot_en;
   logic        cfg_we;
   logic [2:0]  cfg_slot;
   logic [1:0]  cfg_kind;
   logic [31:0] cfg_lo, cfg_hi;
   logic [3:0]  cfg_dst;
   logic        cfg_irq;
   logic [31:0] count;
   logic [FW-1:0] flags;
   logic [NS-1:0] irq_req;
   logic        cfg_err;

   always #5 clk = ~clk;

   hsc_cmp_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
      .cnt_load(cnt_load), .load_val(load_val), .slot_en(slot_en),
      .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_kind(cfg_kind),
      .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_dst(cfg_dst), .cfg_irq(cfg_irq),
      .count(count), .flags(flags), .irq_req(irq_req), .cfg_err(cfg_err)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [31:0]   m_cnt;
   logic [FW-1:0] m_flags;
   logic [NS-1:0] m_irq;
   logic          m_err;
   logic [1:0]    m_kind [NS];
   logic [31:0]   m_lo   [NS];
   logic [31:0]   m_hi   [NS];
   logic [3:0]    m_dst  [NS];
   logic          m_irqm [NS];

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_cnt = '0; m_flags = '0; m_irq = '0; m_err = 1'b0;
      for (int i = 0; i < NS; i++) begin
         m_kind[i] = 2'd3; m_lo[i] = '0; m_hi[i] = '0; m_dst[i] = '0; m_irqm[i] = 1'b0;
      end
   endtask

   task automatic idle_inputs();
      cnt_up = 0; cnt_dn = 0; cnt_load = 0; load_val = '0;
      cfg_we = 0; cfg_slot = '0; cfg_kind = 2'd3; cfg_lo = '0; cfg_hi = '0;
      cfg_dst = '0; cfg_irq = 0;
   endtask

   // One clock: model next state from the requirements, then compare at the ports.
   task automatic tick(string tag);
      logic [31:0]   nx;
      logic          st;
      logic [FW-1:0] f;
      logic [NS-1:0] irq;
      logic          err;
      logic [3:0]    d1, d2;
      logic          b, a;
      st = !cnt_load && (cnt_up ^ cnt_dn);
      if (cnt_load) nx = load_val;
      else if (cnt_up && !cnt_dn) nx = m_cnt + 32'd1;
      else if (cnt_dn && !cnt_up) nx = m_cnt - 32'd1;
      else nx = m_cnt;
      f = m_flags; irq = '0;
      for (int s = 0; s < NS; s++) begin
         if (slot_en[s]) begin
            d1 = m_dst[s] + 4'd1; d2 = m_dst[s] + 4'd2;
            case (m_kind[s])
               2'd0: if (st && nx == m_lo[s]) begin
                  if (m_irqm[s]) irq[s] = 1'b1; else f[m_dst[s]] = 1'b1;
               end
               2'd1: if (st && nx == m_lo[s]) f[m_dst[s]] = 1'b0;
               2'd2: begin
                  b = $signed(nx) < $signed(m_lo[s]);
                  a = $signed(nx) > $signed(m_hi[s]);
                  f[m_dst[s]] = b; f[d1] = !b && !a; f[d2] = a;
               end
               default: ;
            endcase
         end
      end
      err = cfg_we && (cfg_slot < 3'(NS)) && cfg_kind == 2'd2 && ($signed(cfg_lo) > $signed(cfg_hi));
      if (cfg_we && cfg_slot < 3'(NS) && !err) begin
         m_kind[cfg_slot] = cfg_kind; m_lo[cfg_slot] = cfg_lo; m_hi[cfg_slot] = cfg_hi;
         m_dst[cfg_slot] = cfg_dst;   m_irqm[cfg_slot] = cfg_irq;
      end
      @(posedge clk);
      #1;
      m_cnt = nx; m_flags = f; m_irq = irq; m_err = err;
      chk(tag, "count",   count,          m_cnt);
      chk(tag, "flags",   32'(flags),     32'(m_flags));
      chk(tag, "irq_req", 32'(irq_req),   32'(m_irq));
      chk(tag, "cfg_err", 32'(cfg_err),   32'(m_err));
   endtask

   task automatic do_load(string tag, logic [31:0] v);
      cnt_load = 1; load_val = v; tick(tag); idle_inputs();
   endtask

   task automatic do_step(string tag, logic up, logic dn);
      cnt_up = up; cnt_dn = dn; tick(tag); idle_inputs();
   endtask

   task automatic do_cfg(string tag, int slot, logic [1:0] k, logic [31:0] lo,
                         logic [31:0] hi, logic [3:0] dst, logic irqm);
      cfg_we = 1; cfg_slot = 3'(slot); cfg_kind = k; cfg_lo = lo; cfg_hi = hi;
      cfg_dst = dst; cfg_irq = irqm; tick(tag); idle_inputs();
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      idle_inputs();
      slot_en = '0;
      rst_n = 0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1;
      model_reset();
      // R11 reset state
      chk("R11", "count",   count,          32'd0);
      chk("R11", "flags",   32'(flags),     32'd0);
      chk("R11", "irq_req", 32'(irq_req),   32'd0);
      chk("R11", "cfg_err", 32'(cfg_err),   32'd0);
      slot_en = 6'h3f;
      do_step("R11", 1, 0);
      chk("R11", "idle slots leave flags", 32'(flags), 32'd0);

      // R3: set on step from below
      slot_en = '0;
      do_cfg("R12", 0, 2'd0, 32'd200, 32'd0, 4'd3, 1'b0);
      slot_en = 6'b000001;
      do_load("R5", 32'd199);
      do_step("R3", 1, 0);
      chk("R3", "count at 200", count, 32'd200);
      chk("R3", "flag3 set", 32'(flags[3]), 32'd1);
      // R4 + R10: clear slot 1 on same threshold, both fire from above
      do_cfg("R4", 1, 2'd1, 32'd200, 32'd0, 4'd3, 1'b0);
      slot_en = 6'b000011;
      do_load("R4", 32'd201);
      do_step("R10", 0, 1);
      chk("R10", "higher slot clears flag3", 32'(flags[3]), 32'd0);
      // R5: load onto threshold does not fire
      slot_en = 6'b000001;
      do_load("R5", 32'd199);
      do_load("R5", 32'd200);
      chk("R5", "flag3 after load", 32'(flags[3]), 32'd0);
      // R2: cancel
      do_step("R2", 1, 1);
      chk("R2", "up+dn cancel", count, 32'd200);
      chk("R5", "no step no action", 32'(flags[3]), 32'd0);
      // R3 from above
      do_load("R3", 32'd201);
      do_step("R3", 0, 1);
      chk("R3", "flag3 set from above", 32'(flags[3]), 32'd1);

      // R7: reversed range rejected
      do_cfg("R7", 2, 2'd2, 32'd10, 32'd5, 4'd14, 1'b0);
      chk("R7", "cfg_err pulse", 32'(cfg_err), 32'd1);
      slot_en = 6'b000101;
      do_step("R7", 0, 0);
      chk("R7", "err clears", 32'(cfg_err), 32'd0);
      chk("R7", "slot stays idle", 32'(flags), 32'h0008);
      // R6: valid signed range with wrapped index 14,15,0
      do_cfg("R6", 2, 2'd2, 32'hFFFF_FFFB, 32'd5, 4'd14, 1'b0);
      do_load("R6", 32'hFFFF_FFFA);
      chk("R6", "below bit14", 32'(flags), 32'h4008);
      do_load("R6", 32'd5);
      chk("R6", "within bit15", 32'(flags), 32'h8008);
      do_step("R6", 1, 0);
      chk("R6", "above bit0 wrap", 32'(flags), 32'h0009);

      // R8: interrupt routing
      do_cfg("R8", 3, 2'd0, 32'd7, 32'd0, 4'd9, 1'b1);
      slot_en = 6'b001101;
      do_step("R8", 0, 0);
      do_step("R8", 1, 0);
      chk("R8", "irq pulse", 32'(irq_req), 32'h08);
      chk("R8", "flag9 untouched", 32'(flags[9]), 32'd0);
      do_step("R8", 0, 0);
      chk("R8", "irq one cycle", 32'(irq_req), 32'd0);

      // R9: disable freezes, re-enable refreshes range only
      slot_en = 6'b001001;
      do_load("R9", 32'hFFFF_FFF6);
      chk("R9", "range frozen", 32'(flags), 32'h0009);
      slot_en = 6'b001101;
      do_step("R9", 0, 0);
      chk("R9", "range refreshed", 32'(flags), 32'h4008);
      do_cfg("R9", 1, 2'd1, 32'd200, 32'd0, 4'd3, 1'b0);
      slot_en = 6'b000000;
      do_load("R9", 32'd199);
      do_step("R9", 1, 0);
      slot_en = 6'b000010;
      do_step("R9", 0, 0);
      chk("R9", "no equality on re-enable", 32'(flags[3]), 32'd1);
      do_step("R12", 1, 0);
      do_step("R4", 0, 1);
      chk("R4", "clear on step", 32'(flags[3]), 32'd0);
      // R12: out-of-range slot number ignored
      cfg_we = 1; cfg_slot = 3'd7; cfg_kind = 2'd2; cfg_lo = 32'd9; cfg_hi = 32'd1;
      tick("R12"); idle_inputs();
      chk("R12", "no err for slot 7", 32'(cfg_err), 32'd0);

      // Random phase, model compares every cycle
      for (int i = 0; i < 4000; i++) begin
         int r;
         if ($urandom_range(15, 0) == 0) begin
            cfg_we   = 1;
            cfg_slot = 3'($urandom_range(NS - 1, 0));
            cfg_kind = 2'($urandom_range(3, 0));
            r = int'($urandom_range(16, 0)) - 8; cfg_lo = r;
            r = int'($urandom_range(16, 0)) - 8; cfg_hi = r;
            cfg_dst  = 4'($urandom_range(15, 0));
            cfg_irq  = 1'($urandom_range(1, 0));
         end
         if ($urandom_range(9, 0) == 0) begin
            cnt_load = 1;
            r = int'($urandom_range(20, 0)) - 10; load_val = r;
         end
         cnt_up = 1'($urandom_range(1, 0));
         cnt_dn = 1'($urandom_range(1, 0));
         if ($urandom_range(31, 0) == 0) slot_en = 6'($urandom_range(63, 0));
         tick("R2 R3 R4 R6 R8 R10");
         idle_inputs();
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule